// File: doc/BRIEF.md
# SMBus Process Call Sequencer with Packet Error Checking

This block is a byte-level host sequencer for one SMBus Process Call with a trailing error-check byte. A single start pulse launches the whole exchange. The block writes a command code and a 16-bit word to a slave, turns the bus around with a repeated start, and reads back a 16-bit word followed by a check byte. The check byte is compared with a CRC-8 that the block computes over every byte seen on the bus.

The block does not drive the wires itself. It hands one operation at a time to a separate bit-level engine and waits for that engine's completion pulse before it issues the next operation. The engine's operations are start, stop, repeated start, write a byte (which returns the slave's acknowledge) and read a byte (which sends the host's acknowledge or not-acknowledge). When the transaction ends, the block presents the read word, a slave-refusal flag and a check-byte mismatch flag, and it pulses `done`.

Top module: `smbus_pcall_seq`

## Requirements
- R1: The engine operation codes are start=0, stop=1, repeated start=2, write=3 and read=4. A transaction with no refusals issues exactly this order: start, write, write, write, write, repeated start, write, read, read, read, stop.
- R2: The first address byte is {slave_addr, 0} and the address byte after the repeated start is {slave_addr, 1}. Both use the address that was captured when the start pulse was accepted.
- R3: The write that follows the first address carries cmd_code. The next two writes carry wr_word[7:0] and then wr_word[15:8].
- R4: The host acknowledges the first two reads (eng_rd_nack=0) and answers the third read, which is the check byte, with not-acknowledge (eng_rd_nack=1).
- R5: After a transaction with no refusals, rd_word holds {second read byte, first read byte}. rd_word is cleared to zero when a start pulse is accepted.
- R6: pec_err is 1 exactly when the third read byte differs from a CRC-8 computed with polynomial x^8+x^2+x+1 and initial value 0. The CRC covers, in bus order, both address bytes, the command, both written bytes and both read bytes. rd_word is presented whatever the outcome of this comparison.
- R7: If the slave fails to acknowledge any written byte, the next operation issued is stop. No further byte is written or read, nack_err is 1, and pec_err is 0.
- R8: done is high for exactly one cycle after the stop operation completes. rd_word, nack_err and pec_err hold their values until the next accepted start.
- R9: A start pulse that arrives while a transaction is in progress has no effect on the operations or bytes issued, and it produces no second done.
- R10: After reset, done, nack_err, pec_err, rd_word and eng_req are all zero.
- R11: eng_req is never asserted while an earlier operation is still waiting for eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches a transaction; accepted only when idle |
| slave_addr | input | 7 | 7-bit slave address |
| cmd_code | input | 8 | Command code byte |
| wr_word | input | 16 | Word written to the slave |
| eng_done | input | 1 | Engine completion pulse for the outstanding operation |
| eng_slave_ack | input | 1 | Slave acknowledged the written byte; valid with eng_done |
| eng_rdata | input | 8 | Byte read from the slave; valid with eng_done |
| rd_word | output | 16 | Word read back from the slave |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nack_err | output | 1 | A slave acknowledge was missing |
| pec_err | output | 1 | The received check byte did not match the local CRC |
| eng_req | output | 1 | One-cycle request for an engine operation |
| eng_op | output | 3 | Operation code for the engine |
| eng_wdata | output | 8 | Byte to write, valid with eng_req on a write |
| eng_rd_nack | output | 1 | Host answers a read with not-acknowledge |

## Verification
The bench sweeps every point where a slave refusal can occur, including the address byte sent after the turnaround. It also sweeps intact and corrupted check bytes, several data patterns and several engine latencies. If the abort path is wrong, the block keeps writing or reading after a refusal, or it never stops. If the CRC coverage is wrong, for example it misses the second address byte or includes the check byte itself, pec_err comes out set on clean transfers. A start pulse injected mid-transfer exposes a design that re-latches its operands or restarts, because the bytes on the bus then change or a second done appears.

// File: rtl/smbus_pcall_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the Process Call sequencer: engine opcodes,
// sequencer steps and the CRC-8 byte update. Assumes 8-bit bus bytes.
package smbus_pcall_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_STOP   = 3'd1,
        OP_RSTART = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4
    } eng_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDR_W, ST_CMD, ST_DLO, ST_DHI,
        ST_RSTART, ST_ADDR_R, ST_RLO, ST_RHI, ST_RPEC, ST_STOP, ST_DONE
    } step_e;

    // Fold one byte into a running MSB-first CRC-8.
    function automatic logic [BYTE_W-1:0] crc8_next(
        input logic [BYTE_W-1:0] crc,
        input logic [BYTE_W-1:0] data,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] x;
        x = crc ^ data;
        for (int i = 0; i < BYTE_W; i++) begin
            x = x[BYTE_W-1] ? ((x << 1) ^ poly) : (x << 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/pcall_crc8.sv
`timescale 1ns/1ps
// Running CRC-8 accumulator. Cleared to INIT on clear, folds in one byte
// per feed strobe. Assumes clear and feed are never high together.
module pcall_crc8
    import smbus_pcall_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07,
    parameter logic [BYTE_W-1:0] INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              feed,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] crc
);

    logic [BYTE_W-1:0] crc_q;

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= INIT;
        else if (clear)  crc_q <= INIT;
        else if (feed)   crc_q <= crc8_next(crc_q, byte_in, POLY);
    end

    assign crc = crc_q;

endmodule

// File: rtl/pcall_rx_capture.sv
`timescale 1ns/1ps
// Collects the two read bytes into a word and compares the trailing
// check byte against the local CRC. Assumes the CRC already covers
// both read bytes by the time the check strobe arrives.
module pcall_rx_capture
    import smbus_pcall_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              lo_stb,
    input  logic              hi_stb,
    input  logic              pec_stb,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] crc,
    output logic [WORD_W-1:0] rd_word,
    output logic              pec_err
);

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              pec_err_q;

    // Capture the read bytes and the check verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lo_q      <= '0;
            hi_q      <= '0;
            pec_err_q <= 1'b0;
        end else begin
            if (lo_stb)  lo_q      <= rx_byte;
            if (hi_stb)  hi_q      <= rx_byte;
            if (pec_stb) pec_err_q <= (rx_byte != crc);
        end
    end

    assign rd_word = {hi_q, lo_q};
    assign pec_err = pec_err_q;

endmodule

// File: rtl/pcall_step_fsm.sv
`timescale 1ns/1ps
// Step sequencer for one Process Call. Issues a single engine operation
// per step and advances on the engine's completion pulse. A missing slave
// acknowledge diverts to stop. Assumes eng_done only pulses for an
// operation that was requested.
module pcall_step_fsm
    import smbus_pcall_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              eng_done,
    input  logic              eng_slave_ack,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [BYTE_W-1:0] eng_wdata,
    output logic              eng_rd_nack,
    output logic              accept,
    output logic              tx_feed,
    output logic              rx_lo_stb,
    output logic              rx_hi_stb,
    output logic              rx_pec_stb,
    output logic              done,
    output logic              nack_err
);

    step_e             state_q, succ;
    eng_op_e           op;
    logic              pending_q, nack_q, step_done, refused, in_step;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [WORD_W-1:0] word_q;

    // Operation, write byte and read answer for the current step.
    always_comb begin
        op          = OP_START;
        eng_wdata   = '0;
        eng_rd_nack = 1'b0;
        unique case (state_q)
            ST_START:  op = OP_START;
            ST_ADDR_W: begin op = OP_WRITE; eng_wdata = {addr_q, 1'b0}; end
            ST_CMD:    begin op = OP_WRITE; eng_wdata = cmd_q; end
            ST_DLO:    begin op = OP_WRITE; eng_wdata = word_q[BYTE_W-1:0]; end
            ST_DHI:    begin op = OP_WRITE; eng_wdata = word_q[WORD_W-1:BYTE_W]; end
            ST_RSTART: op = OP_RSTART;
            ST_ADDR_R: begin op = OP_WRITE; eng_wdata = {addr_q, 1'b1}; end
            ST_RLO:    op = OP_READ;
            ST_RHI:    op = OP_READ;
            ST_RPEC:   begin op = OP_READ; eng_rd_nack = 1'b1; end
            ST_STOP:   op = OP_STOP;
            default:   op = OP_START;
        endcase
    end

    // Successor of each step on a normal completion.
    always_comb begin
        unique case (state_q)
            ST_START:  succ = ST_ADDR_W;
            ST_ADDR_W: succ = ST_CMD;
            ST_CMD:    succ = ST_DLO;
            ST_DLO:    succ = ST_DHI;
            ST_DHI:    succ = ST_RSTART;
            ST_RSTART: succ = ST_ADDR_R;
            ST_ADDR_R: succ = ST_RLO;
            ST_RLO:    succ = ST_RHI;
            ST_RHI:    succ = ST_RPEC;
            ST_RPEC:   succ = ST_STOP;
            ST_STOP:   succ = ST_DONE;
            default:   succ = ST_IDLE;
        endcase
    end

    assign in_step    = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign eng_req    = in_step && !pending_q;
    assign eng_op     = op;
    assign step_done  = pending_q && eng_done;
    assign refused    = step_done && (op == OP_WRITE) && !eng_slave_ack;
    assign accept     = (state_q == ST_IDLE) && start;
    assign tx_feed    = step_done && (op == OP_WRITE);
    assign rx_lo_stb  = step_done && (state_q == ST_RLO);
    assign rx_hi_stb  = step_done && (state_q == ST_RHI);
    assign rx_pec_stb = step_done && (state_q == ST_RPEC);
    assign done       = (state_q == ST_DONE);
    assign nack_err   = nack_q;

    // Step register, operand latches and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nack_q  <= 1'b0;
            addr_q  <= '0;
            cmd_q   <= '0;
            word_q  <= '0;
        end else if (accept) begin
            state_q <= ST_START;
            nack_q  <= 1'b0;
            addr_q  <= slave_addr;
            cmd_q   <= cmd_code;
            word_q  <= wr_word;
        end else if (state_q == ST_DONE) begin
            state_q <= ST_IDLE;
        end else if (refused) begin
            state_q <= ST_STOP;
            nack_q  <= 1'b1;
        end else if (step_done) begin
            state_q <= succ;
        end
    end

    // Track the single outstanding engine operation.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending_q <= 1'b0;
        else if (step_done) pending_q <= 1'b0;
        else if (eng_req)   pending_q <= 1'b1;
    end

endmodule

// File: rtl/smbus_pcall_seq.sv
`timescale 1ns/1ps
// Top of the Process Call sequencer: step sequencer, CRC accumulator and
// read capture. Assumes a bit-level engine that completes each requested
// operation with a one-cycle eng_done pulse.
module smbus_pcall_seq
    import smbus_pcall_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter int                WORD_W   = 16,
    parameter logic [BYTE_W-1:0] CRC_POLY = 8'h07,
    parameter logic [BYTE_W-1:0] CRC_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              eng_done,
    input  logic              eng_slave_ack,
    input  logic [BYTE_W-1:0] eng_rdata,
    output logic [WORD_W-1:0] rd_word,
    output logic              done,
    output logic              nack_err,
    output logic              pec_err,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [BYTE_W-1:0] eng_wdata,
    output logic              eng_rd_nack
);

    localparam int ADDR_BYTE_W = ADDR_W + 1;

    logic              accept, tx_feed, lo_stb, hi_stb, pec_stb, crc_feed;
    logic [BYTE_W-1:0] crc, crc_byte;

    // Parameter sanity: address plus direction bit fills a byte, word is two bytes.
    initial begin
        if (ADDR_BYTE_W != BYTE_W || WORD_W != 2 * BYTE_W)
            $error("smbus_pcall_seq: unsupported widths");
    end

    pcall_step_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .slave_addr(slave_addr),
        .cmd_code(cmd_code), .wr_word(wr_word), .eng_done(eng_done),
        .eng_slave_ack(eng_slave_ack), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wdata(eng_wdata), .eng_rd_nack(eng_rd_nack), .accept(accept),
        .tx_feed(tx_feed), .rx_lo_stb(lo_stb), .rx_hi_stb(hi_stb),
        .rx_pec_stb(pec_stb), .done(done), .nack_err(nack_err)
    );

    // CRC input: written bytes as sent, read data bytes as received.
    assign crc_feed = tx_feed | lo_stb | hi_stb;
    assign crc_byte = tx_feed ? eng_wdata : eng_rdata;

    pcall_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .feed(crc_feed),
        .byte_in(crc_byte), .crc(crc)
    );

    pcall_rx_capture #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(accept), .lo_stb(lo_stb),
        .hi_stb(hi_stb), .pec_stb(pec_stb), .rx_byte(eng_rdata), .crc(crc),
        .rd_word(rd_word), .pec_err(pec_err)
    );

endmodule

// File: rtl/smbus_pcall_checker.sv
`timescale 1ns/1ps
// Protocol checker for the Process Call sequencer, observing only the
// engine handshake and the result outputs. Bound to the top below.
module smbus_pcall_checker
    import smbus_pcall_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic       eng_done,
    input logic       eng_slave_ack,
    input logic       eng_rd_nack,
    input logic       done
);

    logic       outstanding, abort_pend, expect_start;
    logic [2:0] last_op;
    logic [1:0] read_cnt;

    // Shadow of the handshake: outstanding op, refusal seen, reads so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding  <= 1'b0;
            abort_pend   <= 1'b0;
            expect_start <= 1'b1;
            last_op      <= 3'd0;
            read_cnt     <= 2'd0;
        end else begin
            if (eng_req) begin
                outstanding  <= 1'b1;
                last_op      <= eng_op;
                abort_pend   <= 1'b0;
                expect_start <= 1'b0;
                if (eng_op == 3'(OP_START))     read_cnt <= 2'd0;
                else if (eng_op == 3'(OP_READ)) read_cnt <= read_cnt + 2'd1;
            end else if (eng_done && outstanding) begin
                outstanding <= 1'b0;
                if (last_op == 3'(OP_WRITE) && !eng_slave_ack) abort_pend <= 1'b1;
            end
            if (done) expect_start <= 1'b1;
        end
    end

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !outstanding); // R11
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && abort_pend) |-> (eng_op == 3'(OP_STOP))); // R7
    AST_PEC_READ_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 3'(OP_READ)) |-> (eng_rd_nack == (read_cnt == 2'd2))); // R4
    AST_OPENS_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && expect_start) |-> (eng_op == 3'(OP_START))); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

endmodule

bind smbus_pcall_seq smbus_pcall_checker u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_op(eng_op),
    .eng_done(eng_done), .eng_slave_ack(eng_slave_ack),
    .eng_rd_nack(eng_rd_nack), .done(done)
);

// File: tb/smbus_pcall_seq_bench.sv
`timescale 1ns/1ps
module smbus_pcall_seq_bench;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [6:0]  slave_addr = '0;
    logic [7:0]  cmd_code = '0;
    logic [15:0] wr_word = '0;
    logic        eng_done = 1'b0, eng_slave_ack = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic [15:0] rd_word;
    logic        done, nack_err, pec_err, eng_req, eng_rd_nack;
    logic [2:0]  eng_op;
    logic [7:0]  eng_wdata;

    int checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    smbus_pcall_seq u_smbus_pcall_seq (.*);

    // Engine model state and operation log.
    int        lat = 1, cd = 0, nack_at = 5, wcount = 0, rcount = 0, log_n = 0;
    int        log_op [0:15];
    int        log_byte [0:15];
    int        log_rnack [0:15];
    logic [7:0] s_rlo, s_rhi, s_pec;
    int        done_cnt = 0;
    logic [15:0] cap_word;
    logic      cap_nack, cap_pec;

    // Expected sequence built by the bench.
    int exp_n;
    int exp_op [0:15];
    int exp_byte [0:15];

    task automatic chk(input string tag, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x;
        x = c ^ b;
        for (int i = 0; i < 8; i++) x = {x[6:0], 1'b0} ^ (x[7] ? 8'h07 : 8'h00);
        return x;
    endfunction

    // Engine model: record each request, answer it after lat cycles.
    always @(negedge clk) begin
        cycles++;
        if (eng_done) eng_done = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                eng_done = 1'b1;
                if (log_op[log_n-1] == 3) begin
                    eng_slave_ack = (wcount != nack_at);
                    wcount++;
                end else if (log_op[log_n-1] == 4) begin
                    eng_rdata = (rcount == 0) ? s_rlo : (rcount == 1) ? s_rhi : s_pec;
                    rcount++;
                end
            end
        end else if (eng_req) begin
            if (log_n < 16) begin
                log_op[log_n]    = int'(eng_op);
                log_byte[log_n]  = int'(eng_wdata);
                log_rnack[log_n] = int'(eng_rd_nack);
                log_n++;
            end
            cd = lat;
        end
        if (done) begin
            done_cnt++;
            cap_word = rd_word;
            cap_nack = nack_err;
            cap_pec  = pec_err;
        end
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_txn(input logic [6:0] a, input logic [7:0] c, input logic [15:0] w,
                           input logic [7:0] rlo, input logic [7:0] rhi, input int nk,
                           input bit corrupt, input int l, input bit inject);
        logic [7:0] wb [0:4];
        logic [7:0] crc;
        bit         ok, ok2;
        int         t;
        wb[0] = {a, 1'b0}; wb[1] = c; wb[2] = w[7:0]; wb[3] = w[15:8]; wb[4] = {a, 1'b1};
        crc = 8'h00;
        for (int i = 0; i < 5; i++) crc = crc_upd(crc, wb[i]);
        crc = crc_upd(crc, rlo);
        crc = crc_upd(crc, rhi);
        // Expected operations: start W0 W1 W2 W3 rstart W4 R R R stop, cut at a refusal.
        exp_n = 0;
        exp_op[exp_n++] = 0;
        for (int k = 0; k < 5; k++) begin
            if (k == 4) exp_op[exp_n++] = 2;
            exp_byte[exp_n] = int'(wb[k]);
            exp_op[exp_n++] = 3;
            if (k == nk) break;
        end
        if (nk > 4) for (int r = 0; r < 3; r++) exp_op[exp_n++] = 4;
        exp_op[exp_n++] = 1;

        @(negedge clk);
        log_n = 0; wcount = 0; rcount = 0; done_cnt = 0;
        nack_at = nk; lat = l;
        s_rlo = rlo; s_rhi = rhi; s_pec = corrupt ? (crc ^ (8'h01 << (l & 7))) : crc;
        slave_addr = a; cmd_code = c; wr_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (6) @(negedge clk);
            slave_addr = ~a; cmd_code = ~c; wr_word = ~w; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 500) begin @(negedge clk); t++; end
        chk("R8 done seen", done_cnt == 1, done_cnt, 1);
        repeat (4) @(negedge clk);

        ok = (log_n == exp_n);
        for (int i = 0; i < exp_n && ok; i++) ok = (log_op[i] == exp_op[i]);
        chk(nk > 4 ? "R1 op order" : "R7 op order after refusal", ok, log_n, exp_n);
        ok = 1; ok2 = 1;
        for (int i = 0; i < exp_n && i < log_n; i++) if (exp_op[i] == 3 && log_op[i] == 3) begin
            if (exp_byte[i] == int'(wb[0]) && i == 1 || i == 6) ok = ok && (log_byte[i] == exp_byte[i]);
            else ok2 = ok2 && (log_byte[i] == exp_byte[i]);
        end
        chk("R2 address bytes", ok, log_byte[1], exp_byte[1]);
        chk("R3 command and word bytes", ok2, log_byte[2], exp_byte[2]);
        chk("R7 nack_err", cap_nack == (nk <= 4), cap_nack, nk <= 4);
        if (nk > 4) begin
            ok = (log_rnack[7] == 0) && (log_rnack[8] == 0) && (log_rnack[9] == 1);
            chk("R4 read answers", ok, {log_rnack[7][0], log_rnack[8][0], log_rnack[9][0]}, 3'b001);
            chk("R5 rd_word", cap_word == {rhi, rlo}, cap_word, {rhi, rlo});
            chk("R6 pec_err", cap_pec == corrupt, cap_pec, corrupt);
        end else begin
            chk("R5 rd_word cleared on refusal", cap_word == 16'h0, cap_word, 0);
            chk("R7 pec_err clear on refusal", cap_pec == 1'b0, cap_pec, 0);
        end
        chk("R8 single done and held flags",
            done_cnt == 1 && rd_word == cap_word && nack_err == cap_nack && pec_err == cap_pec,
            done_cnt, 1);
        if (inject) chk("R9 mid-transfer start ignored", log_n == exp_n && done_cnt == 1, log_n, exp_n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", done == 0 && nack_err == 0 && pec_err == 0 &&
            rd_word == 0 && eng_req == 0, {done, nack_err, pec_err, eng_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", eng_req == 0 && done == 0, eng_req, 0);
        for (int nk = 0; nk <= 5; nk++)
            for (int cr = 0; cr < 2; cr++)
                for (int p = 0; p < 4; p++) begin
                    logic [6:0]  a;
                    logic [7:0]  c;
                    logic [15:0] w;
                    a = 7'(8'h16 + 8'(p * 29) + 8'(nk * 3));
                    c = 8'(8'hA5 ^ (p * 8'h3C));
                    w = 16'(16'h1234 * (p + 1) + nk * 16'h0101);
                    run_txn(a, c, w, 8'(8'h5A + p * 17), 8'(8'hC3 - p * 9), nk, cr[0], 1 + (p % 3), 1'b0);
                end
        run_txn(7'h3B, 8'h10, 16'hBEEF, 8'h01, 8'h80, 5, 1'b0, 2, 1'b1);
        run_txn(7'h7F, 8'hFF, 16'hFFFF, 8'hFF, 8'hFF, 5, 1'b1, 3, 1'b1);
        run_txn(7'h00, 8'h00, 16'h0000, 8'h00, 8'h00, 4, 1'b0, 1, 1'b1);
        run_txn(7'h00, 8'h00, 16'h0000, 8'h00, 8'h00, 5, 1'b0, 1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule